// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

This block is a single-port synchronous static memory whose write data arrives on a later clock edge than its command. Address and control are taken on one edge. The matching write data is sampled once the same number of advancing edges has passed as a read needs to present its data. Because the two delays match, a controller can put a read, a write, a read and so on, on every clock with no idle cycle between them.

A static mode pin selects the timing. Pipelined timing registers the read data and has a delay of two edges. Flow-through timing drives the read data straight from the array and has a delay of one edge.

Each 36-bit word is split into four 9-bit lanes, and each lane has its own write enable. A clock enable freezes the whole block when it is low.

Top module: `lateWriteSram`

## Requirements
- R1: A command is taken only on a rising edge where `clkEn` is 1 and `chipSel` is 1. It is a write when `writeN` is 0 and a read when `writeN` is 1. A write seen while `chipSel` is 0 leaves memory unchanged.
- R2: `byteEn[i]` (active high) enables lane i, which is bits 9*i+8 down to 9*i of the word. A write updates only the enabled lanes, and the other lanes keep their stored value.
- R3: A write command with `byteEn` equal to 0 leaves the addressed word unchanged.
- R4: When `flowMode` is 0, the write data on `dIn` is sampled on the second advancing edge after the command edge.
- R5: When `flowMode` is 0, the read data and `dValid`=1 appear just after the second advancing edge following the read command.
- R6: When `flowMode` is 1, the read data and `dValid`=1 appear just after the command edge itself. This is one edge earlier than in pipelined mode.
- R7: When `flowMode` is 1, the write data is sampled on the first advancing edge after the command edge.
- R8: Reads and writes may alternate on consecutive edges in either mode. A read issued right after a write to the same address returns the new enabled lanes merged over the old word.
- R9: While `clkEn` is 0, every stage holds its contents. This covers pending writes, pending reads, `dOut` and `dValid`, and no command is taken.
- R10: `dValid` is 1 only while `dOut` carries read data, and reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| clkEn | input | 1 | Clock enable; when low, the whole block stalls |
| chipSel | input | 1 | Chip select, active high |
| writeN | input | 1 | Write strobe, active low |
| byteEn | input | 4 | Per-lane write enables, active high |
| addr | input | ADDR_W (8) | Word address |
| flowMode | input | 1 | Timing select: 1 for flow-through, 0 for pipelined; static |
| dIn | input | 36 | Late write data |
| dOut | output | 36 | Read data |
| dValid | output | 1 | High while `dOut` holds read data |

## Verification
The main stream is a pipelined sequence that mixes the following patterns:
- Full-word writes, and partial writes on the low lanes and on the top lane.
- A write with no lane enabled.
- A write issued while deselected.
- Reads placed right before and right after writes to the same address.

A latency that is off by one edge shows up as the wrong word or as `dValid` in the wrong cycle, because each write's data differs from the data driven on the neighbouring edges. A wrong lane boundary shows up in the merged words, since their expected values cross hex-digit boundaries. Flow-through mode is run separately, with a masked write to lane 0 and a stall. A pipelined run with stalls placed inside the write window checks that only advancing edges are counted.

// File: rtl/lws_pkg.sv
`timescale 1ns/1ps
package lws_pkg;
  localparam int LWS_LANES  = 4;
  localparam int LWS_LANE_W = 9;
  localparam int LWS_WORD_W = LWS_LANES * LWS_LANE_W;

  // Strobes from control to datapath
  typedef struct packed {
    logic                 wrFire;   // commit a write this edge
    logic [LWS_LANES-1:0] wrMask;   // lanes to commit
    logic                 rdLoad;   // load the registered output
    logic                 useFlow;  // present unregistered array data
  } lwsStrobe_t;
endpackage

// File: rtl/lwsCtrl.sv
`timescale 1ns/1ps
module lwsCtrl
  import lws_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clkEn,
  input  logic                 chipSel,
  input  logic                 writeN,
  input  logic                 flowMode,
  input  logic [LWS_LANES-1:0] byteEn,
  input  logic [ADDR_W-1:0]    addr,
  output lwsStrobe_t           strb,
  output logic [ADDR_W-1:0]    accAddr,
  output logic                 dValid
);
  logic                 s1Valid, s1Write, s2Valid, s2Write, outValid;
  logic [LWS_LANES-1:0] s1Be, s2Be;
  logic [ADDR_W-1:0]    s1Addr, s2Addr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      s1Write  <= 1'b0;
      s1Be     <= '0;
      s1Addr   <= '0;
      s2Valid  <= 1'b0;
      s2Write  <= 1'b0;
      s2Be     <= '0;
      s2Addr   <= '0;
      outValid <= 1'b0;
    end else if (clkEn) begin
      s1Valid  <= chipSel;
      s1Write  <= !writeN;
      s1Be     <= byteEn;
      s1Addr   <= addr;
      s2Valid  <= s1Valid;
      s2Write  <= s1Write;
      s2Be     <= s1Be;
      s2Addr   <= s1Addr;
      outValid <= s2Valid && !s2Write;
    end
  end

  // The stage at which data meets the array depends on the mode
  logic                 tgtValid, tgtWrite;
  logic [LWS_LANES-1:0] tgtBe;

  always_comb begin
    tgtValid = flowMode ? s1Valid : s2Valid;
    tgtWrite = flowMode ? s1Write : s2Write;
    tgtBe    = flowMode ? s1Be    : s2Be;
    accAddr  = flowMode ? s1Addr  : s2Addr;

    strb.wrFire  = clkEn && tgtValid && tgtWrite && (|tgtBe);
    strb.wrMask  = tgtBe;
    strb.rdLoad  = clkEn && s2Valid && !s2Write && !flowMode;
    strb.useFlow = flowMode;

    dValid = flowMode ? (s1Valid && !s1Write) : outValid;
  end

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && !chipSel) |=> !s1Valid); // R1
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> ($stable(s1Valid) && $stable(s2Valid) && $stable(outValid) && $stable(dValid))); // R9
  AST_PIPE_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (!flowMode && clkEn && s2Valid && !s2Write) |=> dValid); // R5
  AST_FLOW_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (flowMode && clkEn && chipSel && writeN) |=> dValid); // R6
endmodule

// File: rtl/lwsDatapath.sv
`timescale 1ns/1ps
module lwsDatapath
  import lws_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  lwsStrobe_t            strb,
  input  logic [ADDR_W-1:0]     accAddr,
  input  logic [LWS_WORD_W-1:0] dIn,
  output logic [LWS_WORD_W-1:0] dOut
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LWS_WORD_W-1:0] mem [DEPTH];
  logic [LWS_WORD_W-1:0] rdWord, outReg;

  assign rdWord = mem[accAddr];

  always_ff @(posedge clk) begin
    if (strb.wrFire) begin
      for (int lane = 0; lane < LWS_LANES; lane++) begin
        if (strb.wrMask[lane])
          mem[accAddr][lane*LWS_LANE_W +: LWS_LANE_W] <= dIn[lane*LWS_LANE_W +: LWS_LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            outReg <= '0;
    else if (strb.rdLoad) outReg <= rdWord;
  end

  assign dOut = strb.useFlow ? rdWord : outReg;

  AST_WRITE_HAS_LANE: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrFire |-> (strb.wrMask != '0)); // R3
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdLoad |=> $stable(outReg)); // R9
endmodule

// File: rtl/lateWriteSram.sv
`timescale 1ns/1ps
module lateWriteSram
  import lws_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  clkEn,
  input  logic                  chipSel,
  input  logic                  writeN,
  input  logic [LWS_LANES-1:0]  byteEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  flowMode,
  input  logic [LWS_WORD_W-1:0] dIn,
  output logic [LWS_WORD_W-1:0] dOut,
  output logic                  dValid
);
  lwsStrobe_t        strb;
  logic [ADDR_W-1:0] accAddr;

  lwsCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .chipSel(chipSel), .writeN(writeN),
    .flowMode(flowMode), .byteEn(byteEn), .addr(addr),
    .strb(strb), .accAddr(accAddr), .dValid(dValid)
  );

  lwsDatapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .accAddr(accAddr), .dIn(dIn), .dOut(dOut)
  );
endmodule

// File: tb/lateWriteSram_bench.sv
`timescale 1ns/1ps
module lateWriteSram_bench;
  logic        clk = 1'b0;
  logic        rstN, clkEn, chipSel, writeN, flowMode;
  logic [3:0]  byteEn;
  logic [7:0]  addr;
  logic [35:0] dIn, dOut;
  logic        dValid;
  int          nChecks = 0, nFails = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  lateWriteSram u_lateWriteSram (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .chipSel(chipSel), .writeN(writeN),
    .byteEn(byteEn), .addr(addr), .flowMode(flowMode), .dIn(dIn),
    .dOut(dOut), .dValid(dValid)
  );

  typedef struct packed {
    logic        en, cs, wn;
    logic [3:0]  be;
    logic [7:0]  a;
    logic [35:0] d;
    logic        ev;
    logic [35:0] ed;
  } vec_t;

  // Pipelined stream: one entry per edge; expected outputs are just after that edge
  localparam vec_t PIPE_VEC [15] = '{
    '{1'b1,1'b1,1'b0,4'hF,8'd1,36'h000000000,1'b0,36'h0},          // e0  W A1 full
    '{1'b1,1'b1,1'b0,4'hF,8'd2,36'h000000000,1'b0,36'h0},          // e1  W A2 full
    '{1'b1,1'b1,1'b1,4'h0,8'd1,36'hFFFFFFFFF,1'b0,36'h0},          // e2  R A1, data of e0
    '{1'b1,1'b1,1'b0,4'h3,8'd1,36'h123456789,1'b0,36'h0},          // e3  W A1 lanes0-1, data of e1
    '{1'b1,1'b1,1'b1,4'h0,8'd1,36'h000000000,1'b1,36'hFFFFFFFFF},  // e4  R A1 (after write)
    '{1'b1,1'b1,1'b1,4'h0,8'd2,36'h000000000,1'b0,36'h0},          // e5  R A2, data of e3
    '{1'b1,1'b1,1'b0,4'h8,8'd2,36'h000000000,1'b1,36'hFFFFC0000},  // e6  W A2 lane3
    '{1'b1,1'b1,1'b0,4'h0,8'd1,36'h000000000,1'b1,36'h123456789},  // e7  W A1 no lanes
    '{1'b1,1'b1,1'b1,4'h0,8'd2,36'hFFFFFFFFF,1'b0,36'h0},          // e8  R A2, data of e6
    '{1'b1,1'b1,1'b1,4'h0,8'd1,36'hFFFFFFFFF,1'b0,36'h0},          // e9  R A1, data of e7 ignored
    '{1'b1,1'b0,1'b0,4'hF,8'd1,36'h000000000,1'b1,36'hFFB456789},  // e10 deselected write
    '{1'b1,1'b0,1'b1,4'h0,8'd0,36'h000000000,1'b1,36'hFFFFC0000},  // e11 idle
    '{1'b1,1'b1,1'b1,4'h0,8'd1,36'hFFFFFFFFF,1'b0,36'h0},          // e12 R A1
    '{1'b1,1'b0,1'b1,4'h0,8'd0,36'h000000000,1'b0,36'h0},          // e13 idle
    '{1'b1,1'b0,1'b1,4'h0,8'd0,36'h000000000,1'b1,36'hFFFFC0000}   // e14 idle
  };

  task automatic step(input logic en, cs, wn, input logic [3:0] be,
                      input logic [7:0] a, input logic [35:0] d);
    clkEn = en; chipSel = cs; writeN = wn; byteEn = be; addr = a; dIn = d;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic expV, input logic [35:0] expD);
    nChecks++;
    if (dValid !== expV) begin
      nFails++;
      $display("FAIL %s: dValid actual %b expected %b", tag, dValid, expV);
    end else if (expV && dOut !== expD) begin
      nFails++;
      $display("FAIL %s: dOut actual %h expected %h", tag, dOut, expD);
    end
  endtask

  task automatic doReset(input logic mode);
    rstN = 1'b0; flowMode = mode;
    clkEn = 1'b1; chipSel = 1'b0; writeN = 1'b1; byteEn = '0; addr = '0; dIn = '0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  initial begin
    doReset(1'b0);
    check("R10 reset clears dValid", 1'b0, 36'h0);

    // R1 R2 R3 R4 R5 R8 R10: pipelined stream
    for (int i = 0; i < 15; i++) begin
      step(PIPE_VEC[i].en, PIPE_VEC[i].cs, PIPE_VEC[i].wn, PIPE_VEC[i].be,
           PIPE_VEC[i].a, PIPE_VEC[i].d);
      check($sformatf("R1 R2 R3 R4 R5 R8 R10 pipelined step %0d", i),
            PIPE_VEC[i].ev, PIPE_VEC[i].ed);
    end

    // Flow-through mode
    doReset(1'b1);
    check("R10 reset in flow mode", 1'b0, 36'h0);
    step(1'b1,1'b1,1'b0,4'hF,8'd5,36'h0);
    check("R7 flow write command", 1'b0, 36'h0);
    step(1'b1,1'b1,1'b1,4'h0,8'd5,36'h0F0F0F0F0);
    check("R6 R7 R8 flow read after write", 1'b1, 36'h0F0F0F0F0);
    step(1'b1,1'b1,1'b0,4'h1,8'd5,36'h0);
    check("R8 flow write after read", 1'b0, 36'h0);
    step(1'b1,1'b1,1'b1,4'h0,8'd5,36'h0);
    check("R2 R6 flow lane0 merge", 1'b1, 36'h0F0F0F000);
    step(1'b0,1'b1,1'b0,4'hF,8'd5,36'h123123123);
    check("R9 flow stall holds read", 1'b1, 36'h0F0F0F000);
    step(1'b1,1'b0,1'b1,4'h0,8'd0,36'h0);
    check("R9 R10 flow stall took no command", 1'b0, 36'h0);
    step(1'b1,1'b1,1'b1,4'h0,8'd5,36'h0);
    check("R9 flow stalled write ignored", 1'b1, 36'h0F0F0F000);

    // Pipelined with stalls inside the write window
    doReset(1'b0);
    step(1'b1,1'b1,1'b0,4'hF,8'd7,36'h0);
    step(1'b0,1'b0,1'b1,4'h0,8'd0,36'h111111111);
    step(1'b1,1'b0,1'b1,4'h0,8'd0,36'h111111111);
    step(1'b1,1'b1,1'b1,4'h0,8'd7,36'h5A5A5A5A5);
    step(1'b1,1'b0,1'b1,4'h0,8'd0,36'h0);
    check("R5 pipelined read not yet valid", 1'b0, 36'h0);
    step(1'b0,1'b0,1'b1,4'h0,8'd0,36'h0);
    check("R9 stall delays read", 1'b0, 36'h0);
    step(1'b1,1'b0,1'b1,4'h0,8'd0,36'h0);
    check("R4 R9 data taken on second advancing edge", 1'b1, 36'h5A5A5A5A5);
    step(1'b0,1'b1,1'b0,4'hF,8'd7,36'h0);
    check("R9 stall holds pipelined output", 1'b1, 36'h5A5A5A5A5);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule